// File: doc/BRIEF.md
# Stack-Based Control-Transfer Sequencer

This block carries out the control-transfer instructions of an 8-bit processor core with a 16-bit address space. It handles subroutine calls, both plain and conditional, and returns, both plain and conditional. It also handles the eight restart vectors, the count-down loop branch on an 8-bit counter register, and the absolute jump through a register pair. The core hands over the already-decoded instruction kind, a 3-bit field, the four condition flags and the current program counter, stack pointer, counter register and register pair with a one-cycle `start` strobe. The sequencer then drives a byte-wide memory port on its own. It fetches operand bytes at the program counter, pushes and pops return addresses, and spends the idle cycles each instruction kind needs.

The stack grows downward. A push pre-decrements the stack pointer and stores the high byte first, then the low byte. A pop reads the low byte and then the high byte, post-incrementing after each. The memory read port is combinational: data for `mem_addr` must be valid in the same cycle as `mem_rd`. Writes take effect at the clock edge that ends a cycle with `mem_wr` high.

The controller is a single state machine with these states: IDLE (waits for `start`), FETCH_LO and FETCH_HI (call target bytes), GAP (idle cycles timed by a loadable counter, left through one of four exits: PUSH, POP, DISP, BRANCH), PUSH_HI and PUSH_LO, POP_LO and POP_HI, FETCH_DISP (loop displacement), JUMP (register-pair load) and DONE (one-cycle completion). The transitions are:
- IDLE to FETCH_LO for either call kind.
- IDLE to GAP for return, restart and loop.
- IDLE to JUMP for the pair jump.
- IDLE to DONE for the reserved kind.
- FETCH_LO to FETCH_HI.
- FETCH_HI to GAP if the condition holds, otherwise to DONE.
- GAP through the PUSH exit to PUSH_HI.
- GAP through the POP exit to POP_LO if the condition holds, otherwise to DONE.
- GAP through the DISP exit to FETCH_DISP.
- GAP through the BRANCH exit to DONE.
- PUSH_HI to PUSH_LO, then to DONE.
- POP_LO to POP_HI, then to DONE.
- FETCH_DISP to GAP if the decremented counter is non-zero, otherwise to DONE.
- JUMP to DONE.
- DONE to IDLE.

Top module: `ctl_xfer_seq`

## Requirements
- R1: After reset `pc_out`, `sp_out`, `cnt_out` and `cycles` are zero, `done` is low and neither `mem_rd` nor `mem_wr` is asserted.
- R2: `op_cc` selects the tested flag by its upper two bits (0 zero flag, 1 carry, 2 parity/overflow, 3 sign) and its bit 0 gives the value that makes the condition true. The codes 0..7 therefore mean: zero clear, zero set, carry clear, carry set, parity odd, parity even, plus, minus.
- R3: `op_kind` 0 (call) and 1 (conditional call) read the target low byte at `pc_in`, then the high byte at `pc_in+1`. When taken, the call spends one idle cycle, pushes `pc_in+2`, loads the target and leaves SP lowered by 2, for 5 work cycles.
- R4: A conditional call whose condition is false makes no stack access, ends with PC = `pc_in+2` and SP unchanged, and takes 2 work cycles.
- R5: Every push writes the high byte of the return address at SP-1 and in the next cycle the low byte at SP-2.
- R6: `op_kind` 4 (restart) with vector v in `op_cc` spends one idle cycle, pushes `pc_in` and sets PC to v*8, for 3 work cycles.
- R7: `op_kind` 2 (return) and 3 (conditional return) always spend one idle cycle. When taken, the return reads the low byte at SP and the high byte at SP+1, loads PC from them and raises SP by 2, for 3 work cycles. A false conditional return changes nothing and takes 1 work cycle.
- R8: `op_kind` 5 (loop) spends one idle cycle, reads a signed displacement at `pc_in` and decrements the counter modulo 256. If the result is zero, PC becomes `pc_in+1` after 2 work cycles. Otherwise, after 5 more idle cycles, PC becomes `pc_in+1` plus the sign-extended displacement, for 7 work cycles.
- R9: `op_kind` 6 loads PC from `pair_in` in 1 work cycle with no memory access. `op_kind` 7 completes in 0 work cycles with PC, SP and counter unchanged.
- R10: `done` is high for exactly one cycle, the cycle after the last memory write or register update. `cycles` then holds the work-cycle count, and `start` is ignored outside IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (sampled in IDLE only) |
| op_kind | input | 3 | Instruction kind (0..7, see R3-R9 encodings) |
| op_cc | input | 3 | Condition code or restart vector |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_pv | input | 1 | Parity/overflow flag |
| flag_s | input | 1 | Sign flag |
| pc_in | input | 16 | Address of the byte after the opcode |
| sp_in | input | 16 | Stack pointer at start |
| pair_in | input | 16 | Register pair for the absolute jump |
| cnt_in | input | 8 | Loop counter register at start |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle of `mem_rd` |
| pc_out | output | 16 | Program counter |
| sp_out | output | 16 | Stack pointer |
| cnt_out | output | 8 | Loop counter register |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 8 | Work cycles of the last instruction |

## Verification
Two situations are hardest to reach. The first is telling a wrong flag selection apart from a correct one. The second is showing that a `start` raised in mid-instruction has no effect. The stimulus covers the first by running every condition code with both values of the tested flag, and each time drives the other three flags to the opposite value. It covers the second by holding `start` high during a taken loop branch, with a different kind, PC and register pair on the inputs, until the `done` cycle. A loop with the counter entering at zero forces the wrap to 255, which takes the long branch path.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [2:0] {
        K_CALL    = 3'd0,
        K_CALL_CC = 3'd1,
        K_RET     = 3'd2,
        K_RET_CC  = 3'd3,
        K_RST     = 3'd4,
        K_LOOP    = 3'd5,
        K_JP_PAIR = 3'd6,
        K_RSVD    = 3'd7
    } xfer_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_GAP,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_POP_LO,
        ST_POP_HI,
        ST_FETCH_DISP,
        ST_JUMP,
        ST_DONE
    } xfer_state_e;

    typedef enum logic [1:0] {
        AG_PUSH,
        AG_POP,
        AG_DISP,
        AG_BRANCH
    } gap_exit_e;

endpackage

// File: rtl/xfer_cond_eval.sv
module xfer_cond_eval #(
    parameter int CC_W   = 3,
    parameter int NFLAGS = 4
) (
    input  logic [CC_W-1:0]   cc,
    input  logic [NFLAGS-1:0] flags,   // index 0 zero, 1 carry, 2 parity/overflow, 3 sign
    output logic              hit
);
    logic [NFLAGS-1:0] match;

    // one comparator per flag; the code's upper bits pick which one counts
    for (genvar g = 0; g < NFLAGS; g++) begin : g_match
        assign match[g] = (flags[g] == cc[0]);
    end

    assign hit = match[cc[CC_W-1:1]];
endmodule

// File: rtl/xfer_gap_timer.sv
module xfer_gap_timer #(
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [GW-1:0] load_val,
    input  logic          run,
    output logic          last
);
    logic [GW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - GW'(1);
        end
    end

    assign last = (cnt_q == GW'(1));
endmodule

// File: rtl/ctl_xfer_seq.sv
module ctl_xfer_seq
    import xfer_pkg::*;
#(
    parameter int DW             = 8,
    parameter int CW             = 8,
    parameter int CYC_W          = 8,
    parameter int CALL_GAP       = 1,
    parameter int RST_GAP        = 1,
    parameter int RET_GAP        = 1,
    parameter int LOOP_GAP       = 1,
    parameter int LOOP_TAKEN_GAP = 5,
    parameter int VEC_SHIFT      = 3,
    localparam int AW            = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_kind,
    input  logic [2:0]    op_cc,
    input  logic          flag_z,
    input  logic          flag_c,
    input  logic          flag_pv,
    input  logic          flag_s,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] pair_in,
    input  logic [CW-1:0] cnt_in,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc_out,
    output logic [AW-1:0] sp_out,
    output logic [CW-1:0] cnt_out,
    output logic          done,
    output logic [CYC_W-1:0] cycles
);
    localparam int GAP_SUM = CALL_GAP + RST_GAP + RET_GAP + LOOP_GAP + LOOP_TAKEN_GAP;
    localparam int GW      = $clog2(GAP_SUM + 1);

    xfer_state_e     state_q, state_d;
    xfer_kind_e      kind_q;
    gap_exit_e       exit_q, exit_d;
    logic [2:0]      cc_q;
    logic [3:0]      flags_q;
    logic [AW-1:0]   pc_q, sp_q, tgt_q;
    logic [CW-1:0]   b_q, b_dec;
    logic [DW-1:0]   disp_q, lo_q;
    logic [CYC_W-1:0] cyc_q;
    logic            gap_load, gap_last, cond_hit, cond_ok;
    logic [GW-1:0]   gap_len;
    logic [AW-1:0]   rst_vec, disp_ext;

    xfer_cond_eval #(.CC_W(3), .NFLAGS(4)) u_cond (
        .cc    (cc_q),
        .flags (flags_q),
        .hit   (cond_hit)
    );

    xfer_gap_timer #(.GW(GW)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_len),
        .run      (state_q == ST_GAP),
        .last     (gap_last)
    );

    assign cond_ok  = (kind_q == K_CALL || kind_q == K_RET) ? 1'b1 : cond_hit;
    assign b_dec    = b_q - CW'(1);
    assign rst_vec  = {{(AW-3){1'b0}}, cc_q} << VEC_SHIFT;
    assign disp_ext = {{DW{disp_q[DW-1]}}, disp_q};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and idle-counter load
    always_comb begin
        state_d  = state_q;
        exit_d   = exit_q;
        gap_load = 1'b0;
        gap_len  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unique case (xfer_kind_e'(op_kind))
                        K_CALL, K_CALL_CC: state_d = ST_FETCH_LO;
                        K_RET, K_RET_CC: begin
                            state_d  = ST_GAP;
                            gap_load = 1'b1;
                            gap_len  = GW'(RET_GAP);
                            exit_d   = AG_POP;
                        end
                        K_RST: begin
                            state_d  = ST_GAP;
                            gap_load = 1'b1;
                            gap_len  = GW'(RST_GAP);
                            exit_d   = AG_PUSH;
                        end
                        K_LOOP: begin
                            state_d  = ST_GAP;
                            gap_load = 1'b1;
                            gap_len  = GW'(LOOP_GAP);
                            exit_d   = AG_DISP;
                        end
                        K_JP_PAIR: state_d = ST_JUMP;
                        K_RSVD:    state_d = ST_DONE;
                    endcase
                end
            end
            ST_FETCH_LO: state_d = ST_FETCH_HI;
            ST_FETCH_HI: begin
                if (cond_ok) begin
                    state_d  = ST_GAP;
                    gap_load = 1'b1;
                    gap_len  = GW'(CALL_GAP);
                    exit_d   = AG_PUSH;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_GAP: begin
                if (gap_last) begin
                    unique case (exit_q)
                        AG_PUSH:   state_d = ST_PUSH_HI;
                        AG_POP:    state_d = cond_ok ? ST_POP_LO : ST_DONE;
                        AG_DISP:   state_d = ST_FETCH_DISP;
                        AG_BRANCH: state_d = ST_DONE;
                    endcase
                end
            end
            ST_PUSH_HI: state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = ST_DONE;
            ST_POP_LO:  state_d = ST_POP_HI;
            ST_POP_HI:  state_d = ST_DONE;
            ST_FETCH_DISP: begin
                if (b_dec != '0) begin
                    state_d  = ST_GAP;
                    gap_load = 1'b1;
                    gap_len  = GW'(LOOP_TAKEN_GAP);
                    exit_d   = AG_BRANCH;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_JUMP: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // architectural registers and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_CALL;
            exit_q  <= AG_PUSH;
            cc_q    <= '0;
            flags_q <= '0;
            pc_q    <= '0;
            sp_q    <= '0;
            tgt_q   <= '0;
            b_q     <= '0;
            disp_q  <= '0;
            lo_q    <= '0;
            cyc_q   <= '0;
        end else begin
            exit_q <= exit_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        kind_q  <= xfer_kind_e'(op_kind);
                        cc_q    <= op_cc;
                        flags_q <= {flag_s, flag_pv, flag_c, flag_z};
                        pc_q    <= pc_in;
                        sp_q    <= sp_in;
                        tgt_q   <= pair_in;
                        b_q     <= cnt_in;
                        cyc_q   <= '0;
                    end
                end
                ST_FETCH_LO: begin
                    tgt_q[DW-1:0] <= mem_rdata;
                    pc_q          <= pc_q + AW'(1);
                    cyc_q         <= cyc_q + CYC_W'(1);
                end
                ST_FETCH_HI: begin
                    tgt_q[AW-1:DW] <= mem_rdata;
                    pc_q           <= pc_q + AW'(1);
                    cyc_q          <= cyc_q + CYC_W'(1);
                end
                ST_GAP: begin
                    cyc_q <= cyc_q + CYC_W'(1);
                    if (gap_last && exit_q == AG_BRANCH) begin
                        pc_q <= pc_q + disp_ext;
                    end
                end
                ST_PUSH_HI: begin
                    sp_q  <= sp_q - AW'(1);
                    cyc_q <= cyc_q + CYC_W'(1);
                end
                ST_PUSH_LO: begin
                    sp_q  <= sp_q - AW'(1);
                    pc_q  <= (kind_q == K_RST) ? rst_vec : tgt_q;
                    cyc_q <= cyc_q + CYC_W'(1);
                end
                ST_POP_LO: begin
                    lo_q  <= mem_rdata;
                    sp_q  <= sp_q + AW'(1);
                    cyc_q <= cyc_q + CYC_W'(1);
                end
                ST_POP_HI: begin
                    pc_q  <= {mem_rdata, lo_q};
                    sp_q  <= sp_q + AW'(1);
                    cyc_q <= cyc_q + CYC_W'(1);
                end
                ST_FETCH_DISP: begin
                    disp_q <= mem_rdata;
                    pc_q   <= pc_q + AW'(1);
                    b_q    <= b_dec;
                    cyc_q  <= cyc_q + CYC_W'(1);
                end
                ST_JUMP: begin
                    pc_q  <= tgt_q;
                    cyc_q <= cyc_q + CYC_W'(1);
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        unique case (state_q)
            ST_FETCH_LO, ST_FETCH_HI, ST_FETCH_DISP: begin
                mem_rd   = 1'b1;
                mem_addr = pc_q;
            end
            ST_PUSH_HI: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_q - AW'(1);
                mem_wdata = pc_q[AW-1:DW];
            end
            ST_PUSH_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_q - AW'(1);
                mem_wdata = pc_q[DW-1:0];
            end
            ST_POP_LO, ST_POP_HI: begin
                mem_rd   = 1'b1;
                mem_addr = sp_q;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign pc_out  = pc_q;
    assign sp_out  = sp_q;
    assign cnt_out = b_q;
    assign cycles  = cyc_q;
endmodule

// File: rtl/xfer_seq_checker.sv
module xfer_seq_checker
    import xfer_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8,
    parameter int VS = 3,
    localparam int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] pc_out,
    input logic [AW-1:0] sp_out,
    input logic [CW-1:0] cnt_out,
    input xfer_state_e   state_q,
    input xfer_kind_e    kind_q,
    input logic          cond_ok
);
    localparam int VEC_COUNT = 8;

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_push_below_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == AW'(sp_out - AW'(1))));

    p_push_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH_HI) |=> (mem_wr && mem_addr == AW'($past(mem_addr) - AW'(1))));

    p_pop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POP_LO) |=> (sp_out == AW'($past(sp_out) + AW'(1))));

    p_skip_call_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_HI && !cond_ok) |=> (done && !mem_rd && !mem_wr));

    p_rst_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == K_RST) |->
            ((pc_out % AW'(1 << VS)) == '0 && (pc_out >> VS) < AW'(VEC_COUNT)));

    p_loop_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_DISP) |=> (cnt_out == CW'($past(cnt_out) - CW'(1))));
endmodule

bind ctl_xfer_seq xfer_seq_checker #(.DW(DW), .CW(CW), .VS(VEC_SHIFT)) u_chk (.*);

// File: tb/ctl_xfer_seq_tb.sv
module ctl_xfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [2:0]  op_cc = '0;
    logic        flag_z = 1'b0, flag_c = 1'b0, flag_pv = 1'b0, flag_s = 1'b0;
    logic [15:0] pc_in = '0, sp_in = '0, pair_in = '0;
    logic [7:0]  cnt_in = '0;
    logic        mem_rd, mem_wr, done;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, mem_rdata, cnt_out, cycles;

    logic [7:0] mem [0:1023];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int q_rd[$], q_wr[$], q_addr[$], q_wd[$];

    always #5 clk = ~clk;

    ctl_xfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind), .op_cc(op_cc),
        .flag_z(flag_z), .flag_c(flag_c), .flag_pv(flag_pv), .flag_s(flag_s),
        .pc_in(pc_in), .sp_in(sp_in), .pair_in(pair_in), .cnt_in(cnt_in),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pc_out(pc_out), .sp_out(sp_out), .cnt_out(cnt_out),
        .done(done), .cycles(cycles)
    );

    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic add(input int rd, input int wr, input int addr, input int wd);
        q_rd.push_back(rd);
        q_wr.push_back(wr);
        q_addr.push_back(addr & 16'hffff);
        q_wd.push_back(wd & 8'hff);
    endtask

    task automatic run_op(input int kind, input int cc, input int z, input int c,
                          input int pv, input int s, input int pc, input int sp,
                          input int b, input int pair, input bit disturb,
                          input string req);
        int epc, esp, eb, tgt, ret, d, fl[4], n;
        bit taken, pushed;
        q_rd.delete(); q_wr.delete(); q_addr.delete(); q_wd.delete();
        fl[0] = z; fl[1] = c; fl[2] = pv; fl[3] = s;
        // condition table: code/2 picks zero, carry, parity, sign; code bit 0 is the wanted value
        taken = (fl[cc / 2] == (cc % 2));
        epc = pc; esp = sp; eb = b; pushed = 1'b0; ret = 0;
        case (kind)
            0, 1: begin
                tgt = mem[pc & 1023] | (mem[(pc + 1) & 1023] << 8);
                add(1, 0, pc, 0);
                add(1, 0, pc + 1, 0);
                epc = pc + 2;
                if (kind == 0 || taken) begin
                    ret = epc;
                    add(0, 0, 0, 0);
                    add(0, 1, sp - 1, ret >> 8);
                    add(0, 1, sp - 2, ret);
                    esp = sp - 2; epc = tgt; pushed = 1'b1;
                end
            end
            2, 3: begin
                add(0, 0, 0, 0);
                if (kind == 2 || taken) begin
                    add(1, 0, sp, 0);
                    add(1, 0, sp + 1, 0);
                    epc = mem[sp & 1023] | (mem[(sp + 1) & 1023] << 8);
                    esp = sp + 2;
                end
            end
            4: begin
                ret = pc;
                add(0, 0, 0, 0);
                add(0, 1, sp - 1, ret >> 8);
                add(0, 1, sp - 2, ret);
                esp = sp - 2; epc = cc * 8; pushed = 1'b1;
            end
            5: begin
                add(0, 0, 0, 0);
                add(1, 0, pc, 0);
                d = mem[pc & 1023];
                epc = pc + 1;
                eb = (b - 1) & 255;
                if (eb != 0) begin
                    for (int k = 0; k < 5; k++) add(0, 0, 0, 0);
                    epc = (epc + ((d >= 128) ? d - 256 : d)) & 16'hffff;
                end
            end
            6: begin
                add(0, 0, 0, 0);
                epc = pair;
            end
            default: ;
        endcase
        add(0, 0, 0, 0);
        n = q_rd.size();

        @(negedge clk);
        op_kind = kind[2:0]; op_cc = cc[2:0];
        flag_z = z[0]; flag_c = c[0]; flag_pv = pv[0]; flag_s = s[0];
        pc_in = pc[15:0]; sp_in = sp[15:0]; cnt_in = b[7:0]; pair_in = pair[15:0];
        start = 1'b1;
        @(negedge clk);
        if (disturb) begin
            // R10: a second start with different inputs while busy
            op_kind = 3'd6; pair_in = 16'hffff; pc_in = 16'h0000;
        end else begin
            start = 1'b0;
        end
        for (int k = 0; k < n; k++) begin
            bit last;
            last = (k == n - 1);
            if (q_rd[k] != 0 || q_wr[k] != 0)
                chk(mem_rd == q_rd[k][0] && mem_wr == q_wr[k][0] && mem_addr == q_addr[k][15:0]
                    && (q_wr[k] == 0 || mem_wdata == q_wd[k][7:0]),
                    req, $sformatf("access cycle %0d {rd,wr,addr,wdata}", k),
                    {mem_rd, mem_wr, mem_addr, mem_wdata},
                    {q_rd[k][0], q_wr[k][0], q_addr[k][15:0], q_wd[k][7:0]});
            else
                chk(!mem_rd && !mem_wr, req, $sformatf("idle cycle %0d {rd,wr}", k),
                    {mem_rd, mem_wr}, 0);
            chk(done == last, "R10", $sformatf("done at cycle %0d", k), done, last);
            if (last) start = 1'b0;
            else @(negedge clk);
        end
        chk(pc_out == epc[15:0], req, "pc_out", pc_out, epc & 16'hffff);
        chk(sp_out == esp[15:0], req, "sp_out", sp_out, esp & 16'hffff);
        chk(cnt_out == eb[7:0], req, "cnt_out", cnt_out, eb & 255);
        chk(cycles == 8'(n - 1), "R10", "cycles", cycles, n - 1);
        if (pushed) begin
            chk(mem[(sp - 1) & 1023] == 8'(ret >> 8), "R5", "stacked high byte",
                mem[(sp - 1) & 1023], (ret >> 8) & 255);
            chk(mem[(sp - 2) & 1023] == 8'(ret), "R5", "stacked low byte",
                mem[(sp - 2) & 1023], ret & 255);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 7 + 3) & 255);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(pc_out == 0 && sp_out == 0 && cnt_out == 0 && cycles == 0, "R1",
            "pc/sp/cnt/cycles after reset", {pc_out, sp_out, cnt_out, cycles}, 0);
        chk(!done && !mem_rd && !mem_wr, "R1", "done/rd/wr after reset",
            {done, mem_rd, mem_wr}, 0);

        // R3: unconditional call
        mem[16'h100] = 8'h34; mem[16'h101] = 8'h02;
        run_op(0, 0, 0, 0, 0, 0, 16'h100, 16'h300, 8'h11, 0, 1'b0, "R3");

        // R2 / R4: every condition code with the tested flag at both values
        mem[16'h140] = 8'h80; mem[16'h141] = 8'h01;
        for (int cc = 0; cc < 8; cc++) begin
            for (int v = 0; v < 2; v++) begin
                int f[4];
                for (int j = 0; j < 4; j++) f[j] = (j == cc / 2) ? v : 1 - v;
                run_op(1, cc, f[0], f[1], f[2], f[3], 16'h140, 16'h3f0, 8'h22, 0, 1'b0,
                       ((cc % 2) == v) ? "R2" : "R4");
            end
        end

        // R6: all restart vectors
        for (int v = 0; v < 8; v++)
            run_op(4, v, 0, 0, 0, 0, 16'h200 + v, 16'h380, 8'h33, 0, 1'b0, "R6");

        // R7: returns
        mem[16'h220] = 8'hcd; mem[16'h221] = 8'h03;
        run_op(2, 0, 0, 0, 0, 0, 16'h050, 16'h220, 8'h44, 0, 1'b0, "R7");
        run_op(3, 7, 1, 1, 1, 0, 16'h060, 16'h220, 8'h44, 0, 1'b0, "R7");
        run_op(3, 6, 1, 1, 1, 0, 16'h060, 16'h220, 8'h44, 0, 1'b0, "R7");

        // R8: loop branch backward (with a start held while busy), fall-through, wrap from zero
        mem[16'h150] = 8'hfe;
        run_op(5, 0, 0, 0, 0, 0, 16'h150, 16'h300, 5, 0, 1'b1, "R8");
        run_op(5, 0, 0, 0, 0, 0, 16'h150, 16'h300, 1, 0, 1'b0, "R8");
        mem[16'h160] = 8'h10;
        run_op(5, 0, 0, 0, 0, 0, 16'h160, 16'h300, 0, 0, 1'b0, "R8");

        // R9: pair jump and reserved kind
        run_op(6, 0, 0, 0, 0, 0, 16'h070, 16'h310, 8'h55, 16'h1234, 1'b0, "R9");
        run_op(7, 0, 0, 0, 0, 0, 16'h080, 16'h320, 8'h66, 16'h4321, 1'b0, "R9");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule